// File: doc/BRIEF.md
# Extended High-ROM Cartridge Address Decoder

This block turns a console CPU bus address (an 8-bit bank and a 16-bit offset) and its read and write strobes into device selects and local addresses for a cartridge with up to 8 MB of ROM in the extended high-ROM layout. The ROM is split into two halves. The first 4 MB fills the upper banks, one whole 64 KB bank per CPU bank. The second 4 MB sits in the lower banks. Its top 128 KB there is taken by console work RAM, and the last 64 KB of it comes back in two banks just below the mirror boundary. The upper half of every bank is mirrored into the low half of the bank space, so the CPU vectors in bank $00 land in ROM. The decoder also opens a battery-backed SRAM window and a coprocessor (DSP) window, and it flags the banks that run at fast ROM timing.

The decoding is done by a region classifier that names the target of each access. The region values are OPEN (unmapped), WRAM (console work RAM, which the cartridge never answers), ROM, SRAM and DSP. Each region leads to one select. There are no states and no transitions. A parameter `REG_OUT` adds an optional output register with one cycle of latency. With the default value 0 the path is purely combinational.

Top module: `xhirom_decoder`

## Requirements
- R1: Banks $C0-$FF at any offset give `rom_addr` = (bank-$C0)*$10000 + offset, which lies in the first 4 MB.
- R2: Banks $40-$7D at any offset give `rom_addr` = $400000 + (bank-$40)*$10000 + offset.
- R3: In banks $7E and $7F, `rom_cs`, `sram_cs` and `dsp_cs` all stay low for any offset and any strobe.
- R4: Banks $3E-$3F at offsets $8000-$FFFF give `rom_addr` = $400000 + bank*$10000 + offset, which is the final 64 KB ($7E8000-$7FFFFF).
- R5: Banks $00-$3D at offsets $8000-$FFFF give the same `rom_addr` as the same offset in bank+$40. This does not apply inside the DSP window.
- R6: Banks $80-$BF at offsets $8000-$FFFF give the same `rom_addr` as the same offset in bank+$40.
- R7: `fast` equals bit 7 of the bank, so it is high exactly for banks $80-$FF.
- R8: Banks $B0-$BF at offsets $6000-$7FFF raise `sram_cs`, with `sram_addr` = (bank-$B0)*$2000 + (offset-$6000). This is 17 bits, covering 128 KB.
- R9: Banks $00-$0F at offsets $6000-$7FFF raise `dsp_cs`. This window takes priority over ROM.
- R10: `rom_cs` is raised only when `rd`=1 and `wr`=0. `sram_cs` and `dsp_cs` are raised when `rd` or `wr` is 1. With both strobes at 0, nothing is selected.
- R11: At most one select is high at a time. Offsets $0000-$7FFF of banks $00-$3F and $80-$BF outside the SRAM and DSP windows select nothing.
- R12: With `REG_OUT`=1, every output shows the decode of the inputs from the previous clock edge. While `rst_n` is low, all selects, `fast` and both addresses are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output register and the checks |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| bank | input | 8 | CPU bank byte |
| offset | input | 16 | CPU offset within the bank |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| rom_addr | output | 23 | Linear ROM byte address |
| rom_cs | output | 1 | ROM select, high on reads only |
| sram_addr | output | 17 | Battery-backed SRAM byte address |
| sram_cs | output | 1 | SRAM select |
| dsp_cs | output | 1 | Coprocessor window select |
| fast | output | 1 | Fast ROM timing flag |

## Verification
The hardest region to reach is the small set of ROM bytes that work RAM pushes out of the lower banks. These bytes appear only in the upper halves of banks $3E and $3F, and the bank numbers on either side of them (the $3D/$3E mirror edge and $7D/$7E against work RAM) must resolve in different ways. A directed sweep therefore visits every bank at the six offsets that bound each window, and it pairs each mirrored bank with its source bank to compare the addresses. Random bank, offset and strobe patterns, drawn from a fixed seed, then mix reads, writes and both strobes at once. A second instance with the output register checks that each result arrives one edge later.

// File: rtl/xhirom_pkg.sv
package xhirom_pkg;
    localparam int BANK_W      = 8;
    localparam int OFF_W       = 16;
    localparam int LOW_BANK_W  = BANK_W - 2;
    localparam int ROM_AW      = 1 + LOW_BANK_W + OFF_W;
    localparam int WIN_W       = 13;
    localparam int WIN_BANK_W  = 4;
    localparam int SRAM_AW     = WIN_BANK_W + WIN_W;

    typedef enum logic [2:0] {
        RG_OPEN,
        RG_WRAM,
        RG_ROM,
        RG_SRAM,
        RG_DSP
    } region_e;

    typedef struct packed {
        logic              rom_cs;
        logic [ROM_AW-1:0] rom_addr;
        logic              sram_cs;
        logic [SRAM_AW-1:0] sram_addr;
        logic              dsp_cs;
        logic              fast;
    } dec_out_t;
endpackage

// File: rtl/xhirom_region.sv
module xhirom_region
    import xhirom_pkg::*;
(
    input  logic [BANK_W-1:0] bank,
    input  logic [2:0]        off_top,
    input  logic              rd,
    input  logic              wr,
    output region_e           region,
    output logic              rom_sel,
    output logic              sram_sel,
    output logic              dsp_sel,
    output logic              fast
);
    logic in_window;

    // offset $6000-$7FFF: top three offset bits are 011
    assign in_window = (off_top == 3'b011);
    assign fast      = bank[BANK_W-1];

    always_comb begin
        region = RG_OPEN;
        if (bank[BANK_W-1:1] == 7'h3F) begin
            region = RG_WRAM;
        end else if (in_window && bank[BANK_W-1:4] == 4'h0) begin
            region = RG_DSP;
        end else if (in_window && bank[BANK_W-1:4] == 4'hB) begin
            region = RG_SRAM;
        end else if (bank[BANK_W-2] || off_top[2]) begin
            region = RG_ROM;
        end
    end

    always_comb begin
        rom_sel  = 1'b0;
        sram_sel = 1'b0;
        dsp_sel  = 1'b0;
        unique case (region)
            RG_ROM:  rom_sel  = rd & ~wr;
            RG_SRAM: sram_sel = rd | wr;
            RG_DSP:  dsp_sel  = rd | wr;
            RG_OPEN, RG_WRAM: ;
            default: ;
        endcase
    end
endmodule

// File: rtl/xhirom_addr.sv
module xhirom_addr
    import xhirom_pkg::*;
(
    input  logic                  bank_msb,
    input  logic [LOW_BANK_W-1:0] bank_low,
    input  logic [WIN_BANK_W-1:0] win_bank,
    input  logic [OFF_W-1:0]      offset,
    output logic [ROM_AW-1:0]     rom_addr,
    output logic [SRAM_AW-1:0]    sram_addr
);
    // upper banks are the first half of the ROM, lower banks the second
    assign rom_addr  = {~bank_msb, bank_low, offset};
    assign sram_addr = {win_bank, offset[WIN_W-1:0]};
endmodule

// File: rtl/xhirom_decoder.sv
module xhirom_decoder
    import xhirom_pkg::*;
#(
    parameter bit REG_OUT = 1'b0
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [BANK_W-1:0]   bank,
    input  logic [OFF_W-1:0]    offset,
    input  logic                rd,
    input  logic                wr,
    output logic [ROM_AW-1:0]   rom_addr,
    output logic                rom_cs,
    output logic [SRAM_AW-1:0]  sram_addr,
    output logic                sram_cs,
    output logic                dsp_cs,
    output logic                fast
);
    region_e  region;
    dec_out_t comb_out;
    dec_out_t out_q;

    xhirom_region u_region (
        .bank     (bank),
        .off_top  (offset[OFF_W-1:OFF_W-3]),
        .rd       (rd),
        .wr       (wr),
        .region   (region),
        .rom_sel  (comb_out.rom_cs),
        .sram_sel (comb_out.sram_cs),
        .dsp_sel  (comb_out.dsp_cs),
        .fast     (comb_out.fast)
    );

    xhirom_addr u_addr (
        .bank_msb  (bank[BANK_W-1]),
        .bank_low  (bank[LOW_BANK_W-1:0]),
        .win_bank  (bank[WIN_BANK_W-1:0]),
        .offset    (offset),
        .rom_addr  (comb_out.rom_addr),
        .sram_addr (comb_out.sram_addr)
    );

    generate
        if (REG_OUT) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= comb_out;
            end

            p_latency_r12: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (out_q == $past(comb_out)));
        end else begin : g_comb
            assign out_q = comb_out;
        end
    endgenerate

    assign rom_addr  = out_q.rom_addr;
    assign rom_cs    = out_q.rom_cs;
    assign sram_addr = out_q.sram_addr;
    assign sram_cs   = out_q.sram_cs;
    assign dsp_cs    = out_q.dsp_cs;
    assign fast      = out_q.fast;

    p_one_sel_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({comb_out.rom_cs, comb_out.sram_cs, comb_out.dsp_cs}));

    p_wram_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bank[BANK_W-1:1] == 7'h3F) |->
            !(comb_out.rom_cs || comb_out.sram_cs || comb_out.dsp_cs));

    p_rom_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr |-> !comb_out.rom_cs);

    p_fast_first_half_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (comb_out.rom_cs && comb_out.fast) |-> !comb_out.rom_addr[ROM_AW-1]);

    p_low_second_half_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (comb_out.rom_cs && !bank[BANK_W-1]) |-> comb_out.rom_addr[ROM_AW-1]);

    p_sram_banks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        comb_out.sram_cs |-> (comb_out.fast && bank[BANK_W-1:4] == 4'hB
                              && region == RG_SRAM));

    p_dsp_banks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        comb_out.dsp_cs |-> (!comb_out.fast && offset[OFF_W-1:OFF_W-3] == 3'b011));
endmodule

// File: tb/tb_xhirom_decoder.sv
`timescale 1ns/1ps
module tb_xhirom_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bank = 8'hFF;
    logic [15:0] offset = 16'h8000;
    logic        rd = 1'b1;
    logic        wr = 1'b0;

    logic [22:0] rom_addr, q_rom_addr;
    logic [16:0] sram_addr, q_sram_addr;
    logic        rom_cs, sram_cs, dsp_cs, fast;
    logic        q_rom_cs, q_sram_cs, q_dsp_cs, q_fast;

    int n_run = 0;
    int n_fail = 0;
    logic [63:0] prev_tuple;

    typedef struct packed {
        logic        rom_cs;
        logic [22:0] rom_addr;
        logic        sram_cs;
        logic [16:0] sram_addr;
        logic        dsp_cs;
        logic        fast;
    } exp_t;

    always #10 clk = ~clk;

    xhirom_decoder dut (
        .clk(clk), .rst_n(rst_n), .bank(bank), .offset(offset), .rd(rd), .wr(wr),
        .rom_addr(rom_addr), .rom_cs(rom_cs), .sram_addr(sram_addr),
        .sram_cs(sram_cs), .dsp_cs(dsp_cs), .fast(fast)
    );

    xhirom_decoder #(.REG_OUT(1'b1)) dut_q (
        .clk(clk), .rst_n(rst_n), .bank(bank), .offset(offset), .rd(rd), .wr(wr),
        .rom_addr(q_rom_addr), .rom_cs(q_rom_cs), .sram_addr(q_sram_addr),
        .sram_cs(q_sram_cs), .dsp_cs(q_dsp_cs), .fast(q_fast)
    );

    function automatic exp_t ref_map(input logic [7:0] b, input logic [15:0] o,
                                     input logic r, input logic w);
        exp_t e;
        int   a;
        bit   win;
        e = '0;
        a = 0;
        e.fast = (b >= 8'h80);
        win = (o >= 16'h6000 && o <= 16'h7FFF);
        if (b == 8'h7E || b == 8'h7F) begin
            a = 0;
        end else if (win && b <= 8'h0F) begin
            e.dsp_cs = r | w;
        end else if (win && b >= 8'hB0 && b <= 8'hBF) begin
            e.sram_cs = r | w;
            if (e.sram_cs) e.sram_addr = 17'((int'(b) - 'hB0) * 'h2000 + (int'(o) - 'h6000));
        end else begin
            if (b >= 8'hC0)                  a = (int'(b) - 'hC0) * 'h10000 + int'(o);
            else if (b >= 8'h40 && b < 8'h80) a = 'h400000 + (int'(b) - 'h40) * 'h10000 + int'(o);
            else if (o >= 16'h8000 && b >= 8'h80) a = (int'(b) - 'h80) * 'h10000 + int'(o);
            else if (o >= 16'h8000)          a = 'h400000 + int'(b) * 'h10000 + int'(o);
            else                             a = -1;
            if (a >= 0) begin
                e.rom_cs = r & ~w;
                if (e.rom_cs) e.rom_addr = 23'(a);
            end
        end
        return e;
    endfunction

    function automatic string tag_of(input logic [7:0] b, input logic [15:0] o);
        bit win;
        win = (o >= 16'h6000 && o <= 16'h7FFF);
        if (b == 8'h7E || b == 8'h7F)              return "R3";
        if (win && b <= 8'h0F)                     return "R9";
        if (win && b >= 8'hB0 && b <= 8'hBF)       return "R8";
        if (b >= 8'hC0)                            return "R1";
        if (b >= 8'h40 && b < 8'h80)               return "R2";
        if (o >= 16'h8000 && (b == 8'h3E || b == 8'h3F)) return "R4";
        if (o >= 16'h8000 && b < 8'h40)            return "R5";
        if (o >= 16'h8000)                         return "R6";
        return "R11";
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s bank=%02h off=%04h rd=%0b wr=%0b actual=%0h expected=%0h",
                     tag, what, bank, offset, rd, wr, act, exp);
        end
    endtask

    task automatic apply(input logic [7:0] b, input logic [15:0] o,
                         input logic r, input logic w);
        exp_t  e;
        string t;
        logic [63:0] q_act;
        @(negedge clk);
        bank = b; offset = o; rd = r; wr = w;
        #2;
        e = ref_map(b, o, r, w);
        t = (w && !(b == 8'h7E || b == 8'h7F)) ? "R10" : tag_of(b, o);
        chk(t, "selects", 64'({rom_cs, sram_cs, dsp_cs}),
            64'({e.rom_cs, e.sram_cs, e.dsp_cs}));
        chk(t, "rom_addr", 64'(e.rom_cs ? rom_addr : 23'd0), 64'(e.rom_addr));
        chk(t, "sram_addr", 64'(e.sram_cs ? sram_addr : 17'd0), 64'(e.sram_addr));
        chk("R7", "fast", 64'(fast), 64'(e.fast));
        // R12: registered copy still shows the previous access
        q_act = 64'({q_rom_cs, q_rom_cs ? q_rom_addr : 23'd0,
                     q_sram_cs, q_sram_cs ? q_sram_addr : 17'd0, q_dsp_cs, q_fast});
        chk("R12", "registered", q_act, prev_tuple);
        prev_tuple = 64'(e);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [22:0] a_src;
        logic [15:0] offs [6];
        offs = '{16'h0000, 16'h5FFF, 16'h6000, 16'h7FFF, 16'h8000, 16'hFFFF};
        void'($urandom(32'd4242));

        // R12 reset: registered outputs cleared while reset is held
        repeat (3) @(posedge clk);
        #2;
        chk("R12", "reset", 64'({q_rom_cs, q_sram_cs, q_dsp_cs, q_fast, q_rom_addr, q_sram_addr}), 64'd0);
        @(negedge clk);
        bank = 8'h00; offset = 16'h0000; rd = 1'b0; wr = 1'b0;
        rst_n = 1'b1;
        @(posedge clk);
        prev_tuple = 64'(ref_map(8'h00, 16'h0000, 1'b0, 1'b0));

        // directed sweep of every bank at the window edges
        for (int b = 0; b < 256; b++) begin
            for (int k = 0; k < 6; k++) begin
                apply(8'(b), offs[k], 1'b1, 1'b0);
            end
        end

        // mirror equalities R5 (00-3D vs 40-7D) and R6 (80-BF vs C0-FF)
        for (int b = 16; b < 8'h3E; b += 7) begin
            apply(8'(b + 8'h40), 16'h9ABC, 1'b1, 1'b0);
            a_src = rom_addr;
            apply(8'(b), 16'h9ABC, 1'b1, 1'b0);
            chk("R5", "mirror", 64'(rom_addr), 64'(a_src));
        end
        for (int b = 8'h80; b < 8'hC0; b += 9) begin
            apply(8'(b + 8'h40), 16'hF00D, 1'b1, 1'b0);
            a_src = rom_addr;
            apply(8'(b), 16'hF00D, 1'b1, 1'b0);
            chk("R6", "mirror", 64'(rom_addr), 64'(a_src));
        end

        // R10 strobe corners
        apply(8'hC5, 16'h1234, 1'b0, 1'b1);
        apply(8'hC5, 16'h1234, 1'b1, 1'b1);
        apply(8'hB3, 16'h6001, 1'b0, 1'b1);
        apply(8'h05, 16'h7000, 1'b1, 1'b1);
        apply(8'hB3, 16'h6001, 1'b0, 1'b0);
        apply(8'h7E, 16'h8000, 1'b0, 1'b1);

        // constrained random mix
        for (int i = 0; i < 2000; i++) begin
            logic [7:0]  rb;
            logic [15:0] ro;
            logic [1:0]  st;
            rb = 8'($urandom);
            ro = 16'($urandom);
            st = 2'($urandom);
            if (i % 4 == 0) ro = {3'b011, ro[12:0]};
            if (i % 8 == 1) rb = {7'h3F, rb[0]};
            apply(rb, ro, st[0], st[1]);
        end

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule